// File: doc/BRIEF.md
# Datapath Self-Test Controller with Pseudorandom Stimulus

This block exercises the digital back end of a data converter without any analog input. When software raises the run bit, the converter sample bus is replaced by words from an on-chip pseudorandom generator. Those words pass through the output formatter to the output bus, so the test stream can be watched on the pins. After a fixed number of sample-clock cycles the run stops by itself. During the run, every formatted word is folded into a 16-bit signature. Software reads that signature as two bytes and compares it with a value computed offline for the chosen format.

Control goes through a small byte-wide register port. There are four control bits: run, resume or restart, generator hold, and output format. A status register reports whether a run is in progress and whether the last run has completed. Every register and counter is clocked by the sample clock.

Top module: `dpst_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears everything. `out_data` is 0, `out_test` is 0, and the signature and status registers read 0. The generator state is set to its seed.
- R2: With no run active, `out_data` shows the formatted `adc_sample` one clock after it is sampled, and `out_test` is 0.
- R3: A run lasts exactly 512 sample cycles. `out_test` is high for exactly 512 consecutive output cycles, and each of those cycles carries one test word on `out_data`. When the run ends, status bit 0 (done) is 1 and status bit 1 (busy) is 0.
- R4: The test words are the states of a 16-bit Fibonacci LFSR with taps x^16+x^14+x^13+x^11+1 and seed 0xFFFF. The next state is `{s[14:0], s[15]^s[13]^s[12]^s[10]}`, taken once per run cycle. The first word of a restarted run is 0xFFFF. `adc_sample` has no effect on the output during a run.
- R5: The signature is cleared when a run starts. On each run cycle, the formatted word d updates it as `sig = {sig[14:0], sig[15]^sig[13]^sig[12]^sig[10]} ^ d`. Address 1 reads `sig[7:0]` and address 2 reads `sig[15:8]`.
- R6: Control bit 1 (resume) selects where a run starts. If it is 1, the run continues the sequence from the state the generator holds. If it is 0, the run restarts from the seed.
- R7: While control bit 2 (hold) is 1, the generator is forced to the seed every cycle. A run started with hold set therefore emits 0xFFFF (formatted) on every cycle. After hold is released, a resumed run starts from the seed.
- R8: Control bit 3 selects the output format. With 0, words pass unchanged (offset binary). With 1, the MSB is inverted (two's complement). The signature depends on this setting.
- R9: A run starts only on a rising edge of control bit 0 while no run is active. Starting a run clears done. Dropping and raising bit 0 during a run neither restarts nor extends that run.
- R10: The register map is: address 0 reads back control bits [3:0] (run, resume, hold, format from bit 0 up); address 3 is status {6'b0, busy, done}. The upper four bits of address 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample (encode) clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adc_sample | input | 16 | Converter sample word, offset binary |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| out_data | output | 16 | Formatted output word, registered |
| out_test | output | 1 | High while `out_data` carries a test word |

## Verification
The assertions assume that `rst_n` is held low for at least one edge before any activity. They also assume that format and hold are not rewritten in the middle of a run, because the signature properties and the seed property rely on a stable configuration. The bench changes format and hold only while the block is idle. The only control writes it makes during a run are the drop-and-raise of the run bit, with the other bits unchanged. Expected words are pushed into a scoreboard queue when each run is launched, and the monitor pops one word for each cycle in which `out_test` is high.

// File: rtl/dpst_pkg.sv
// Package dpst_pkg
// Shared register layout, addresses and polynomial for the datapath self-test.
// Assumes a 2-bit register address space.
package dpst_pkg;

    typedef struct packed {
        logic fmt;      // bit 3: 1 = two's complement output
        logic hold;     // bit 2: force generator to seed
        logic resume;   // bit 1: 1 = continue sequence at run start
        logic en;       // bit 0: run request, rising edge starts
    } ctrl_t;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_SIGLO = 2'd1;
    localparam logic [1:0] ADDR_SIGHI = 2'd2;
    localparam logic [1:0] ADDR_STAT  = 2'd3;

    // x^16 + x^14 + x^13 + x^11 + 1 as a feedback tap mask
    localparam logic [15:0] POLY_TAPS = 16'hB400;
    localparam logic [15:0] PN_SEED   = 16'hFFFF;

endpackage

// File: rtl/dpst_lfsr.sv
// Module dpst_lfsr
// Fibonacci LFSR used as the pseudorandom stimulus source.
// It loads SEED on reset or on load_seed, and shifts once per cycle while
// advance is high. Assumes SEED is nonzero and TAPS describes a maximal polynomial.
module dpst_lfsr #(
    parameter int unsigned   W    = 16,
    parameter logic [W-1:0]  TAPS = 16'hB400,
    parameter logic [W-1:0]  SEED = 16'hFFFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_seed,
    input  logic         advance,
    output logic [W-1:0] state
);

    logic feedback;

    // Parity of the tapped bits forms the new LSB.
    always_comb feedback = ^(state & TAPS);

    // Generator register: seed has priority over stepping.
    always_ff @(posedge clk) begin
        if (!rst_n)         state <= SEED;
        else if (load_seed) state <= SEED;
        else if (advance)   state <= {state[W-2:0], feedback};
    end

    AST_PN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);                                           // R4
    AST_HOLD_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        load_seed |=> state == SEED);                           // R7

endmodule

// File: rtl/dpst_misr.sv
// Module dpst_misr
// Multiple-input signature register using the same feedback polynomial as the
// generator. clear has priority over fold; fold absorbs din in one cycle.
module dpst_misr #(
    parameter int unsigned  W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         fold,
    input  logic [W-1:0] din,
    output logic [W-1:0] sig
);

    logic [W-1:0] sig_next;

    // Shift with polynomial feedback, then XOR in the datapath word.
    always_comb sig_next = {sig[W-2:0], ^(sig & TAPS)} ^ din;

    // Signature register.
    always_ff @(posedge clk) begin
        if (!rst_n)     sig <= '0;
        else if (clear) sig <= '0;
        else if (fold)  sig <= sig_next;
    end

    AST_SIG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> sig == '0);                                   // R5
    AST_SIG_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !fold) |=> $stable(sig));                    // R5

endmodule

// File: rtl/dpst_fmt.sv
// Module dpst_fmt
// Output formatter stub. The input is taken as offset binary. Mode 1
// inverts the MSB to give two's complement; mode 0 passes the word unchanged.
module dpst_fmt #(
    parameter int unsigned W = 16
) (
    input  logic         twos,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    // Format select: only the sign bit differs between the codings.
    always_comb begin
        dout        = din;
        dout[W-1]   = din[W-1] ^ twos;
    end

endmodule

// File: rtl/dpst_run.sv
// Module dpst_run
// Run sequencer: counts RUN_LEN cycles after an accepted start, then raises done.
// start requests that arrive while busy are dropped.
module dpst_run #(
    parameter int unsigned RUN_LEN = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    output logic start_fire,
    output logic busy,
    output logic done
);

    localparam int unsigned CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    logic [CW-1:0] count;

    // Accept a start only when idle.
    always_comb start_fire = start_req && !busy;

    // Cycle counter, busy and done flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else if (start_fire) begin
            count <= '0;
            busy  <= 1'b1;
            done  <= 1'b0;
        end else if (busy) begin
            count <= count + 1'b1;
            if (count == LAST) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    AST_END_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);                                  // R3
    AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);                                        // R9
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_req && count != LAST) |=> busy && $past(count) + 1'b1 == count); // R9

endmodule

// File: rtl/dpst_top.sv
// Module dpst_top
// Datapath self-test controller. It holds the control/status registers and
// routes either the converter samples or the generator words through the
// formatter to a registered output, while the signature register compacts the
// formatted stream during a run. Assumes DW >= 8 and a synchronous active-low reset.
module dpst_top
    import dpst_pkg::*;
#(
    parameter int unsigned DW      = 16,
    parameter int unsigned RUN_LEN = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] adc_sample,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [1:0]    rd_addr,
    output logic [7:0]    rd_data,
    output logic [DW-1:0] out_data,
    output logic          out_test
);

    ctrl_t         ctrl_q;
    logic          en_prev;
    logic          start_req;
    logic          start_fire;
    logic          busy;
    logic          done;
    logic          seed_load;
    logic [DW-1:0] pn_word;
    logic [DW-1:0] src_word;
    logic [DW-1:0] fmt_word;
    logic [DW-1:0] sig;
    logic          unused_wr_hi;

    assign unused_wr_hi = ^wr_data[7:4];

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ctrl_q <= '0;
        else if (wr_en && wr_addr == ADDR_CTRL)  ctrl_q <= ctrl_t'(wr_data[3:0]);
    end

    // Delayed run bit for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) en_prev <= 1'b0;
        else        en_prev <= ctrl_q.en;
    end

    // A start request is a rising edge of the run bit.
    always_comb start_req = ctrl_q.en && !en_prev;

    // Seed is forced by hold, or by a restart-mode start.
    always_comb seed_load = ctrl_q.hold || (start_fire && !ctrl_q.resume);

    dpst_run #(.RUN_LEN(RUN_LEN)) i_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .start_fire (start_fire),
        .busy       (busy),
        .done       (done)
    );

    dpst_lfsr #(.W(DW), .TAPS(DW'(POLY_TAPS)), .SEED(DW'(PN_SEED))) i_lfsr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_seed (seed_load),
        .advance   (busy),
        .state     (pn_word)
    );

    // Source select: the generator replaces the converter word during a run.
    always_comb src_word = busy ? pn_word : adc_sample;

    dpst_fmt #(.W(DW)) i_fmt (
        .twos (ctrl_q.fmt),
        .din  (src_word),
        .dout (fmt_word)
    );

    dpst_misr #(.W(DW), .TAPS(DW'(POLY_TAPS))) i_misr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start_fire),
        .fold  (busy),
        .din   (fmt_word),
        .sig   (sig)
    );

    // Output register: formatted word plus a test-word marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_test <= 1'b0;
        end else begin
            out_data <= fmt_word;
            out_test <= busy;
        end
    end

    // Register read mux.
    always_comb begin
        unique case (rd_addr)
            ADDR_CTRL:  rd_data = {4'b0, ctrl_q};
            ADDR_SIGLO: rd_data = sig[7:0];
            ADDR_SIGHI: rd_data = sig[DW-1:DW-8];
            default:    rd_data = {6'b0, busy, done};
        endcase
    end

    AST_OUT_TRACKS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        out_test == $past(busy));                               // R3
    AST_RUN_STARTS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> sig == '0 && !done);                    // R5
    AST_RESTART_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) && !ctrl_q.resume |-> pn_word == DW'(PN_SEED)); // R6

endmodule

// File: tb/test_dpst_top.sv
module test_dpst_top;

    localparam int RUN = 512;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] adc_sample;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [7:0]  wr_data;
    logic [1:0]  rd_addr;
    logic [7:0]  rd_data;
    logic [15:0] out_data;
    logic        out_test;

    int checks = 0;
    int errors = 0;
    int active_seen = 0;
    bit noise_on = 1'b0;
    logic [15:0] exp_q[$];
    logic [15:0] m_pn = 16'hFFFF;
    logic [15:0] m_sig;

    always #10 clk = ~clk;

    dpst_top i_dpst_top (
        .clk(clk), .rst_n(rst_n), .adc_sample(adc_sample),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .out_data(out_data), .out_test(out_test)
    );

    function automatic logic [15:0] lfsr_nx(logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic [15:0] misr_nx(logic [15:0] s, logic [15:0] d);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]} ^ d;
    endfunction

    function automatic logic [15:0] fmt(logic [15:0] w, bit tw);
        return tw ? {~w[15], w[14:0]} : w;
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic reg_wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    // Driver: configure, push the expected words, then raise the run bit.
    task automatic start_run(bit tw, bit res, bit hold);
        logic [7:0]  cfg;
        logic [15:0] st;
        logic [7:0]  s;
        cfg = {4'b0, tw, hold, res, 1'b0};
        reg_wr(2'd0, cfg);
        if (hold) m_pn = 16'hFFFF;
        st = (hold || !res) ? 16'hFFFF : m_pn;
        m_sig = 16'h0000;
        for (int i = 0; i < RUN; i++) begin
            exp_q.push_back(fmt(st, tw));
            m_sig = misr_nx(m_sig, fmt(st, tw));
            st = hold ? 16'hFFFF : lfsr_nx(st);
        end
        m_pn = st;
        active_seen = 0;
        reg_wr(2'd0, cfg | 8'h01);
        reg_rd(2'd3, s);
        check("R9", "done cleared, busy set at start", {24'b0, s}, 32'h2);
    endtask

    // Wait for done, then check run length, scoreboard drain and signature.
    task automatic finish_run(string tag);
        logic [7:0] s;
        logic [7:0] lo;
        logic [7:0] hi;
        do reg_rd(2'd3, s); while (!s[0]);
        @(negedge clk);
        @(negedge clk);
        #2;
        check("R3", {tag, " test cycles"}, active_seen, RUN);
        check("R3", {tag, " scoreboard empty"}, exp_q.size(), 0);
        check("R3", {tag, " status done"}, {24'b0, s}, 32'h1);
        reg_rd(2'd1, lo);
        reg_rd(2'd2, hi);
        check("R5", {tag, " signature"}, {16'b0, hi, lo}, {16'b0, m_sig});
    endtask

    // Monitor: pop one expected word per test cycle.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_test === 1'b1) begin
            active_seen++;
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R3 extra test word actual=%h expected=none", out_data);
            end else begin
                check("R4", "test word", {16'b0, out_data}, {16'b0, exp_q.pop_front()});
            end
        end
    end

    // Converter noise while runs are active (must be ignored, R4).
    initial begin
        forever begin
            @(negedge clk);
            if (noise_on) adc_sample = 16'($urandom);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0]  r;
        logic [15:0] sig_a;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr = '0; adc_sample = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "out_data after reset", {16'b0, out_data}, 0);
        check("R1", "out_test after reset", {31'b0, out_test}, 0);
        rst_n = 1'b1;
        reg_rd(2'd1, r); check("R1", "sig lo reset", {24'b0, r}, 0);
        reg_rd(2'd2, r); check("R1", "sig hi reset", {24'b0, r}, 0);
        reg_rd(2'd3, r); check("R1", "status reset", {24'b0, r}, 0);

        // Idle pass-through in both formats
        adc_sample = 16'h1234;
        @(negedge clk); @(negedge clk);
        check("R2", "idle offset binary", {16'b0, out_data}, 32'h1234);
        check("R2", "idle out_test", {31'b0, out_test}, 0);
        reg_wr(2'd0, 8'h08);
        @(negedge clk);
        check("R8", "idle two's complement", {16'b0, out_data}, 32'h9234);
        reg_rd(2'd0, r); check("R10", "ctrl readback", {24'b0, r}, 32'h08);
        reg_wr(2'd0, 8'hF8);
        reg_rd(2'd0, r); check("R10", "ctrl upper bits read zero", {24'b0, r}, 32'h08);

        noise_on = 1'b1;
        // Restart run, offset binary
        start_run(1'b0, 1'b0, 1'b0); finish_run("R4 restart offset");
        sig_a = m_sig;
        // Resume continues the sequence
        start_run(1'b0, 1'b1, 1'b0); finish_run("R6 resume");
        // Restart in two's complement: signature differs
        start_run(1'b1, 1'b0, 1'b0); finish_run("R8 twos");
        check("R8", "format changes signature", {31'b0, m_sig != sig_a}, 1);
        // Hold forces the seed
        start_run(1'b0, 1'b1, 1'b1); finish_run("R7 hold");
        // Resume after hold release starts from seed
        start_run(1'b0, 1'b1, 1'b0); finish_run("R7 after hold");

        // Re-raising the run bit mid-run is ignored
        start_run(1'b0, 1'b1, 1'b0);
        repeat (100) @(negedge clk);
        reg_wr(2'd0, 8'h02);
        reg_wr(2'd0, 8'h03);
        finish_run("R9 mid-run re-enable");
        repeat (20) @(negedge clk);
        #2;
        check("R9", "no second run", active_seen, RUN);
        reg_rd(2'd3, r); check("R9", "done held", {24'b0, r}, 32'h1);
        reg_wr(2'd0, 8'h02);
        noise_on = 1'b0;

        summary();
        $finish;
    end

endmodule